// File: doc/BRIEF.md
# Vectored Interrupt Status Unit for a Two-Wire Bus Controller

This block sits between the protocol engine of a two-wire serial bus controller and the host. The engine sends one-cycle pulses for seven kinds of event: arbitration lost, no-acknowledge, access ready, receive data ready, transmit data ready, stop detected and addressed as slave. Each pulse sets a sticky pending flag. An enable register selects which pending flags may raise the level interrupt line. A priority encoder turns the enabled pending flags into a single 3-bit vector code.

The host uses a small register port: one read strobe, one write strobe, a 2-bit address and a 16-bit data bus. Read data comes back registered. Reading the vector returns the code of the highest-priority enabled event and retires that event in the same access. The host can therefore poll the vector until it reads zero. Access-ready and stop-detected can also be cleared by writing ones to the status register. The status register also shows two live bus conditions that are not latched.

Top module: `irq_vector_unit`

## Requirements
- R1: After a synchronous reset, the interrupt line is low. A read of the enable (address 0), status (address 1) or vector (address 2) register returns 0 while the live inputs are low.
- R2: An event pulse on `evt_i[k]` latches pending bit k whether or not it is enabled. Bit k is visible as status bit k. The bit order is: 0 arbitration lost, 1 no-acknowledge, 2 access ready, 3 receive ready, 4 transmit ready, 5 stop detected, 6 addressed as slave.
- R3: A vector read (address 2) returns, in bits 2:0, the code k+1 for the lowest k that is both pending and enabled. The codes are: 1 arbitration lost, 2 no-acknowledge, 3 access ready, 4 receive ready, 5 transmit ready, 6 stop detected, 7 addressed as slave. The read returns 0 when nothing enabled is pending, and bits 15:3 are 0.
- R4: A vector read clears only the pending bit it reports. A vector read that returns 0 clears nothing.
- R5: An event that arrives in the same cycle as the vector read that clears it stays pending.
- R6: `irq_o` is high exactly when some pending bit has its enable bit set. A masked pending event does not raise `irq_o` and is not reported by the vector.
- R7: Writing the status register clears pending bit 2 (access ready) and bit 5 (stop detected) where the written data bit is 1. Written ones at the other event positions have no effect.
- R8: Status bit 11 shows `rx_full_i` and bit 12 shows `bus_busy_i` as sampled in the read cycle. Writes to these bit positions are ignored.
- R9: The enable register holds write data bits 6:0, with bit k enabling event k. Bits 15:7 read back as 0. Rewriting it changes the receive-ready (bit 3) and transmit-ready (bit 4) enables one at a time without touching the other enables.
- R10: Read data appears on `host_rdata_o` on the clock edge that samples `host_rd_i` and holds until the next read. Address 3 reads 0. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 7 | One-cycle event pulses, bit k = event k |
| bus_busy_i | input | 1 | Live bus-busy condition |
| rx_full_i | input | 1 | Live receive-shift-register-full condition |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 reserved |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Registered host read data |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check several things on every cycle. An event pulse always leaves its pending bit set on the next edge, including when a clear lands in the same cycle. The interrupt line stays low whenever no enabled flag is pending. A vector read returns a non-zero code exactly when the interrupt line is high. Status reads mirror the live inputs. Other behaviour only the bench scenarios can show: that the priority order picks the lowest code, that a vector read retires exactly one flag, that only the two write-one-to-clear bits respond to status writes, and that enable changes unmask flags that were already latched.

// File: rtl/ivu_pkg.sv
package ivu_pkg;
  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_STAT = 2'd1,
    ADDR_VEC  = 2'd2,
    ADDR_RSVD = 2'd3
  } ivu_addr_e;

  // positions of live (unlatched) bus conditions in the status word
  localparam int STAT_RXFULL_BIT = 11;
  localparam int STAT_BUSY_BIT   = 12;
endpackage

// File: rtl/ivu_pending.sv
// Bank of sticky event flags: set by pulses, cleared by a vector read or a
// write-one-to-clear access, with a same-cycle set winning over a clear.
module ivu_pending #(
  parameter int NUM_EV = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] set_i,
  input  logic [NUM_EV-1:0] clr_i,
  output logic [NUM_EV-1:0] pend_d_o,
  output logic [NUM_EV-1:0] pend_q_o
);
  for (genvar k = 0; k < NUM_EV; k++) begin : g_flag
    logic flag_q;
    logic flag_d;
    assign flag_d = set_i[k] | (flag_q & ~clr_i[k]);
    always_ff @(posedge clk) begin
      if (rst) flag_q <= 1'b0;
      else     flag_q <= flag_d;
    end
    assign pend_d_o[k] = flag_d;
    assign pend_q_o[k] = flag_q;
  end
endmodule

// File: rtl/ivu_prio_enc.sv
// Lowest-index request wins; code is index+1, zero when idle.
module ivu_prio_enc #(
  parameter int NUM_EV = 7,
  parameter int VEC_W  = $clog2(NUM_EV + 1)
) (
  input  logic [NUM_EV-1:0] req_i,
  output logic [VEC_W-1:0]  code_o,
  output logic [NUM_EV-1:0] grant_o
);
  always_comb begin
    code_o  = '0;
    grant_o = '0;
    for (int k = NUM_EV - 1; k >= 0; k--) begin
      if (req_i[k]) begin
        code_o     = VEC_W'(k + 1);
        grant_o    = '0;
        grant_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivu_host_regs.sv
// Enable register and registered read-data path.
module ivu_host_regs
  import ivu_pkg::*;
#(
  parameter int NUM_EV = 7,
  parameter int DATA_W = 16,
  parameter int VEC_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_EV-1:0] pend_i,
  input  logic [VEC_W-1:0]  code_i,
  input  logic              busy_i,
  input  logic              full_i,
  output logic [NUM_EV-1:0] mask_d_o,
  output logic [NUM_EV-1:0] mask_q_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [NUM_EV-1:0] mask_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] stat_word;
  wire unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_EV];

  assign mask_d_o = (wr_i && addr_i == ADDR_MASK) ? wdata_i[NUM_EV-1:0] : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '0;
    else     mask_q <= mask_d_o;
  end

  always_comb begin
    stat_word                  = '0;
    stat_word[NUM_EV-1:0]      = pend_i;
    stat_word[STAT_RXFULL_BIT] = full_i;
    stat_word[STAT_BUSY_BIT]   = busy_i;
  end

  always_comb begin
    unique case (addr_i)
      ADDR_MASK: rd_mux = DATA_W'(mask_q);
      ADDR_STAT: rd_mux = stat_word;
      ADDR_VEC:  rd_mux = DATA_W'(code_i);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign mask_q_o = mask_q;
  assign rdata_o  = rdata_q;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import ivu_pkg::*;
#(
  parameter int          NUM_EV   = 7,
  parameter int          DATA_W   = 16,
  parameter logic [6:0]  W1C_BITS = 7'b0100100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EV-1:0] evt_i,
  input  logic              bus_busy_i,
  input  logic              rx_full_i,
  input  logic              host_wr_i,
  input  logic              host_rd_i,
  input  logic [1:0]        host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              irq_o
);
  localparam int VEC_W = $clog2(NUM_EV + 1);

  logic [NUM_EV-1:0] pend_q;
  logic [NUM_EV-1:0] pend_d;
  logic [NUM_EV-1:0] mask_q;
  logic [NUM_EV-1:0] mask_d;
  logic [NUM_EV-1:0] grant;
  logic [NUM_EV-1:0] clr;
  logic [VEC_W-1:0]  code;
  logic              vec_rd;
  logic              stat_wr;
  logic              irq_q;

  assign vec_rd  = host_rd_i && host_addr_i == ADDR_VEC;
  assign stat_wr = host_wr_i && host_addr_i == ADDR_STAT;
  assign clr     = (vec_rd ? grant : '0)
                 | (stat_wr ? (host_wdata_i[NUM_EV-1:0] & W1C_BITS[NUM_EV-1:0]) : '0);

  ivu_pending #(.NUM_EV(NUM_EV)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .set_i    (evt_i),
    .clr_i    (clr),
    .pend_d_o (pend_d),
    .pend_q_o (pend_q)
  );

  ivu_prio_enc #(.NUM_EV(NUM_EV), .VEC_W(VEC_W)) u_enc (
    .req_i   (pend_q & mask_q),
    .code_o  (code),
    .grant_o (grant)
  );

  ivu_host_regs #(.NUM_EV(NUM_EV), .DATA_W(DATA_W), .VEC_W(VEC_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (host_wr_i),
    .rd_i     (host_rd_i),
    .addr_i   (host_addr_i),
    .wdata_i  (host_wdata_i),
    .pend_i   (pend_q),
    .code_i   (code),
    .busy_i   (bus_busy_i),
    .full_i   (rx_full_i),
    .mask_d_o (mask_d),
    .mask_q_o (mask_q),
    .rdata_o  (host_rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(pend_d & mask_d);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ivu_checker.sv
module ivu_checker #(
  parameter int NUM_EV = 7,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_EV-1:0] evt_i,
  input logic              bus_busy_i,
  input logic              rx_full_i,
  input logic              host_rd_i,
  input logic [1:0]        host_addr_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              irq_o,
  input logic [NUM_EV-1:0] pend_q,
  input logic [NUM_EV-1:0] mask_q
);
  // R1
  irq_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !irq_o);

  // R2 R5
  evt_latched_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R6
  irq_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & mask_q) == '0) |-> !irq_o);

  // R3
  vec_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_i && host_addr_i == 2'd2) |=>
      ((host_rdata_o != '0) == $past(irq_o)) && (host_rdata_o[DATA_W-1:3] == '0));

  // R8
  live_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (host_rd_i && host_addr_i == 2'd1) |=>
      (host_rdata_o[12] == $past(bus_busy_i)) && (host_rdata_o[11] == $past(rx_full_i)));
endmodule

bind irq_vector_unit ivu_checker #(.NUM_EV(NUM_EV), .DATA_W(DATA_W)) u_ivu_chk (
  .clk          (clk),
  .rst          (rst),
  .evt_i        (evt_i),
  .bus_busy_i   (bus_busy_i),
  .rx_full_i    (rx_full_i),
  .host_rd_i    (host_rd_i),
  .host_addr_i  (host_addr_i),
  .host_rdata_o (host_rdata_o),
  .irq_o        (irq_o),
  .pend_q       (pend_q),
  .mask_q       (mask_q)
);

// File: tb/irq_vector_unit_bench.sv
module irq_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  evt = '0;
  logic        busy = 1'b0;
  logic        full = 1'b0;
  logic        wr = 1'b0;
  logic        rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  logic [6:0] pend_m = '0;
  logic [6:0] mask_m = '0;

  localparam int OP_IDLE = 0, OP_RMASK = 1, OP_RSTAT = 2, OP_RVEC = 3,
                 OP_RRSV = 4, OP_WMASK = 5, OP_WSTAT = 6, OP_WVEC = 7;

  always #4 clk = ~clk;

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rst(rst), .evt_i(evt), .bus_busy_i(busy), .rx_full_i(full),
    .host_wr_i(wr), .host_rd_i(rd), .host_addr_i(addr), .host_wdata_i(wdata),
    .host_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [2:0] exp_code(input logic [6:0] p, input logic [6:0] m);
    logic [6:0] r = p & m;
    for (int k = 0; k < 7; k++) if (r[k]) return 3'(k + 1);
    return 3'd0;
  endfunction

  function automatic logic [15:0] exp_stat(input logic [6:0] p, input logic b, input logic f);
    logic [15:0] s = {9'd0, p};
    s[11] = f;
    s[12] = b;
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive after a falling edge, check after the next falling edge
  task automatic cyc(input logic [6:0] ev, input int op, input logic [15:0] wd, input string req);
    logic [15:0] exp_rd;
    logic [2:0]  c;
    c = exp_code(pend_m, mask_m);
    case (op)
      OP_RMASK: exp_rd = {9'd0, mask_m};
      OP_RSTAT: exp_rd = exp_stat(pend_m, busy, full);
      OP_RVEC:  exp_rd = {13'd0, c};
      default:  exp_rd = 16'd0;
    endcase
    evt   = ev;
    rd    = (op >= OP_RMASK && op <= OP_RRSV);
    wr    = (op >= OP_WMASK);
    addr  = (op == OP_RMASK || op == OP_WMASK) ? 2'd0 :
            (op == OP_RSTAT || op == OP_WSTAT) ? 2'd1 :
            (op == OP_RVEC  || op == OP_WVEC)  ? 2'd2 : 2'd3;
    wdata = wd;
    if (op == OP_RVEC && c != 0) pend_m[c-1] = 1'b0;
    if (op == OP_WSTAT) pend_m = pend_m & ~(wd[6:0] & 7'b0100100);
    if (op == OP_WMASK) mask_m = wd[6:0];
    pend_m = pend_m | ev;
    @(negedge clk);
    evt = '0; rd = 1'b0; wr = 1'b0;
    if (op >= OP_RMASK && op <= OP_RRSV)
      check(rdata === exp_rd, req, rdata, exp_rd);
    check(irq === |(pend_m & mask_m), "R6 irq", {15'd0, irq}, {15'd0, |(pend_m & mask_m)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(irq === 1'b0, "R1 irq after reset", {15'd0, irq}, 16'd0);
    cyc(7'd0, OP_RMASK, 16'd0, "R1 mask reset");
    cyc(7'd0, OP_RSTAT, 16'd0, "R1 status reset");
    cyc(7'd0, OP_RVEC,  16'd0, "R1 vector reset");

    // R3 R4 priority and one-at-a-time retire
    cyc(7'd0, OP_WMASK, 16'h007F, "R9 write mask");
    cyc(7'b1010000, OP_IDLE, 16'd0, "R2 pulse");
    cyc(7'd0, OP_RVEC, 16'd0, "R3 vector code 5 first");
    cyc(7'd0, OP_RSTAT, 16'd0, "R4 only bit4 retired");
    cyc(7'd0, OP_RVEC, 16'd0, "R3 vector code 7");
    cyc(7'd0, OP_RVEC, 16'd0, "R4 vector empty");

    // R6 masked events stay latched but silent
    cyc(7'd0, OP_WMASK, 16'h0000, "R9 mask off");
    cyc(7'b0000010, OP_IDLE, 16'd0, "R2 masked pulse");
    cyc(7'd0, OP_RVEC, 16'd0, "R6 masked not reported");
    cyc(7'd0, OP_RSTAT, 16'd0, "R2 masked still latched");
    cyc(7'd0, OP_WMASK, 16'h0002, "R6 unmask raises irq");
    cyc(7'd0, OP_RVEC, 16'd0, "R3 vector code 2");

    // R5 same-cycle event survives its clear
    cyc(7'd0, OP_WMASK, 16'h007F, "R9 mask all");
    cyc(7'b0000100, OP_IDLE, 16'd0, "R2 access ready");
    cyc(7'b0000100, OP_RVEC, 16'd0, "R5 read with new event");
    cyc(7'd0, OP_RVEC, 16'd0, "R5 event still pending");

    // R7 write-one-to-clear
    cyc(7'b0100101, OP_IDLE, 16'd0, "R2 three events");
    cyc(7'd0, OP_WSTAT, 16'h007F, "R7 status w1c");
    cyc(7'd0, OP_RSTAT, 16'd0, "R7 only bits 2 and 5 cleared");
    cyc(7'd0, OP_RVEC, 16'd0, "R7 arbitration lost remains");

    // R8 live bits
    busy = 1'b1; full = 1'b0;
    cyc(7'd0, OP_WSTAT, 16'h1800, "R8 write live bits");
    cyc(7'd0, OP_RSTAT, 16'd0, "R8 busy live");
    busy = 1'b0; full = 1'b1;
    cyc(7'd0, OP_RSTAT, 16'd0, "R8 rx full live");
    full = 1'b0;

    // R9 receive/transmit enables toggled independently
    cyc(7'd0, OP_WMASK, 16'h0018, "R9 rx tx on");
    cyc(7'd0, OP_WMASK, 16'h0008, "R9 tx off");
    cyc(7'd0, OP_RMASK, 16'd0, "R9 readback 08");
    cyc(7'd0, OP_WMASK, 16'hFFFF, "R9 all ones");
    cyc(7'd0, OP_RMASK, 16'd0, "R9 upper bits zero");

    // R10 reserved address and ignored writes
    cyc(7'b0001000, OP_WVEC, 16'hFFFF, "R10 vector write");
    cyc(7'd0, OP_RRSV, 16'd0, "R10 reserved reads zero");
    cyc(7'd0, OP_RVEC, 16'd0, "R10 vector unaffected by write");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] ev;
      ev   = 7'($urandom() & $urandom() & $urandom());
      busy = 1'($urandom());
      full = 1'($urandom());
      cyc(ev, int'($urandom_range(0, 7)), 16'($urandom()), "R3 R4 R7 random");
    end
    repeat (12) cyc(7'd0, OP_RVEC, 16'd0, "R4 drain");
    check(irq === 1'b0 || mask_m == 0, "R4 drained", {15'd0, irq}, 16'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule